// File: doc/BRIEF.md
# Low-Address Write Protection Page Walker

This block screens a multi-page write before any address translation takes place. It decides whether low-address protection applies to the request. That decision uses an enable bit, the translation-on flag and the address-space mode. The mode also picks which of three address-space control elements is handed on to the translator. The block then visits the consecutive logical pages that the request covers, one page per clock. It flags a protection fault as soon as a write lands on a protected low window.

Each page that passes is presented with a valid strobe, so a downstream translator can consume the pages in order. A fault ends the walk at the offending page. When every page passes, a done pulse marks the last page. An access-register mode request with translation on is rejected with a mode error instead of being walked.

Top module: `lap_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `page_valid`, `prot_fault`, `walk_done` and `mode_error` are low.
- R2: `asc_mode` encodings are 00 primary, 01 access-register, 10 secondary and 11 home. Primary mode presents `ce_primary` on `active_ce` and home mode presents `ce_home`; in both, `page_perm` ({read, write, execute}, bit 2 = read) is 3'b111.
- R3: In secondary mode, a fetch (`req_fetch`=1) presents `ce_primary` with `page_perm`=3'b001. A data access presents `ce_secondary` with `page_perm`=3'b110.
- R4: Protection is inactive when `lp_enable` is 0. With `lp_enable`=1 and `xlate_on`=0 it is always active. With `xlate_on`=1 it is active only when bit 8 (private-space bit) of the element chosen by the mode is 0. Secondary mode uses `ce_secondary` for this test even for a fetch.
- R5: A request with `req_write`=0 never produces `prot_fault`.
- R6: When protection is active, a page whose address lies in 0..511 or 4096..4607 raises `prot_fault` in its cycle with `page_valid` low, and the walk ends with no further pages and no `walk_done`.
- R7: A request covers ((req_addr mod 4096) + req_len − 1) / 4096 + 1 pages. They are presented one per cycle starting the cycle after acceptance. The first page address is `req_addr`; each following one is the previous page's 4096-aligned base plus 4096.
- R8: When no page faults, `walk_done` is high in the cycle of the last page, together with its `page_valid`. At most one of `walk_done`, `prot_fault` and `mode_error` is high in any cycle.
- R9: With `xlate_on`=1 and access-register mode, `mode_error` pulses for one cycle, in the cycle after acceptance, and no page is presented. With `xlate_on`=0 the mode is not checked.
- R10: A request with `req_len`=0 produces `walk_done` in the cycle after acceptance, with no page.
- R11: `req_start` is accepted only while `busy` is low. A start during a walk changes neither the page sequence nor `active_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a request (taken when idle) |
| req_addr | input | AW | Logical start address |
| req_len | input | LW | Length in bytes |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch |
| lp_enable | input | 1 | Low-address protection enable |
| xlate_on | input | 1 | Address translation enabled |
| asc_mode | input | 2 | Address-space mode |
| ce_primary | input | EW | Primary space control element |
| ce_secondary | input | EW | Secondary space control element |
| ce_home | input | EW | Home space control element |
| busy | output | 1 | A request is in progress |
| page_valid | output | 1 | `page_addr` holds a page that passed |
| page_addr | output | AW | Current page address |
| active_ce | output | EW | Element selected for the request |
| page_perm | output | 3 | {read, write, execute} permission |
| prot_fault | output | 1 | Protection fault at the current page |
| mode_error | output | 1 | Unsupported address-space mode |
| walk_done | output | 1 | Last page passed |

## Verification
A wrong page counter shows at the ports as `walk_done` arriving one page early or late. It also shows as a page address stepped past the request, and either appears within one page cycle of the wrong count. A wrongly latched protection flag or element choice shows as a missing or spurious `prot_fault` on the first page in a protected window, or a wrong `active_ce`, in the first cycle after acceptance. The boundary addresses 511/512 and 4607/4608, together with a request that crosses into 4096 from below, expose off-by-one window decoding and wrong alignment of the stepped address.

// File: rtl/lap_pkg.sv
package lap_pkg;

    typedef enum logic [1:0] {
        ASC_PRIMARY   = 2'b00,
        ASC_ACCREG    = 2'b01,
        ASC_SECONDARY = 2'b10,
        ASC_HOME      = 2'b11
    } asc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_ERR,
        ST_EMPTY
    } walk_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    localparam perm_t PERM_ALL   = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
    localparam perm_t PERM_EXEC  = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
    localparam perm_t PERM_RDWR  = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};

    // True when an address falls in either protected low window.
    function automatic logic in_low_window(input logic [63:0] a,
                                           input int unsigned pbits,
                                           input int unsigned win);
        logic [63:0] base;
        base = 64'd1 << pbits;
        return (a < 64'(win)) || ((a >= base) && (a < base + 64'(win)));
    endfunction

endpackage

// File: rtl/lap_mode_decode.sv
module lap_mode_decode
    import lap_pkg::*;
#(
    parameter int EW       = 64,
    parameter int PRIV_BIT = 8
) (
    input  logic [1:0]    asc_mode,
    input  logic          is_fetch,
    input  logic          is_write,
    input  logic          prot_enable,
    input  logic          dat_on,
    input  logic [EW-1:0] elem_pri,
    input  logic [EW-1:0] elem_sec,
    input  logic [EW-1:0] elem_home,
    output logic [EW-1:0] elem_sel,
    output perm_t         perm,
    output logic          prot_active,
    output logic          unsupported
);

    asc_mode_e     mode;
    logic [EW-1:0] mode_elem;

    assign mode = asc_mode_e'(asc_mode);

    always_comb begin
        elem_sel  = '0;
        mode_elem = '0;
        perm      = PERM_ALL;
        case (mode)
            ASC_PRIMARY: begin
                elem_sel  = elem_pri;
                mode_elem = elem_pri;
            end
            ASC_HOME: begin
                elem_sel  = elem_home;
                mode_elem = elem_home;
            end
            ASC_SECONDARY: begin
                mode_elem = elem_sec;
                if (is_fetch) begin
                    elem_sel = elem_pri;
                    perm     = PERM_EXEC;
                end else begin
                    elem_sel = elem_sec;
                    perm     = PERM_RDWR;
                end
            end
            default: begin
                elem_sel  = '0;
                mode_elem = '0;
            end
        endcase
    end

    assign prot_active = is_write && prot_enable &&
                         (!dat_on || !mode_elem[PRIV_BIT]);
    assign unsupported = dat_on && (mode == ASC_ACCREG);

endmodule

// File: rtl/lap_page_walker.sv
module lap_page_walker
    import lap_pkg::*;
#(
    parameter int AW        = 64,
    parameter int LW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int LOW_WIN   = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          load_prot,
    output logic [AW-1:0] cur_addr,
    output logic          hit,
    output logic          last
);

    localparam int CW = LW + 1;
    localparam logic [AW-1:0] PG_SIZE = AW'(1) << PAGE_BITS;
    localparam logic [AW-1:0] PG_MASK = PG_SIZE - AW'(1);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] remain_q;
    logic          prot_q;
    logic [CW-1:0] span;
    logic [CW-1:0] count;

    assign span  = CW'(load_addr[PAGE_BITS-1:0]) + CW'(load_len) - CW'(1);
    assign count = (span >> PAGE_BITS) + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
            prot_q   <= 1'b0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= count;
            prot_q   <= load_prot;
        end else if (step) begin
            addr_q   <= (addr_q & ~PG_MASK) + PG_SIZE;
            remain_q <= remain_q - CW'(1);
        end
    end

    assign cur_addr = addr_q;
    assign hit      = prot_q && in_low_window(64'(addr_q), PAGE_BITS, LOW_WIN);
    assign last     = (remain_q == CW'(1));

endmodule

// File: rtl/lap_checker.sv
module lap_checker
    import lap_pkg::*;
#(
    parameter int AW        = 64,
    parameter int LW        = 32,
    parameter int EW        = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_WIN   = 512,
    parameter int PRIV_BIT  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic          lp_enable,
    input  logic          xlate_on,
    input  logic [1:0]    asc_mode,
    input  logic [EW-1:0] ce_primary,
    input  logic [EW-1:0] ce_secondary,
    input  logic [EW-1:0] ce_home,
    output logic          busy,
    output logic          page_valid,
    output logic [AW-1:0] page_addr,
    output logic [EW-1:0] active_ce,
    output logic [2:0]    page_perm,
    output logic          prot_fault,
    output logic          mode_error,
    output logic          walk_done
);

    walk_state_e   st_q, st_d;
    logic [EW-1:0] dec_elem, ce_q;
    perm_t         dec_perm, perm_q;
    logic          dec_prot, dec_unsup;
    logic          accept, hit, last, in_walk;

    lap_mode_decode #(.EW(EW), .PRIV_BIT(PRIV_BIT)) u_dec (
        .asc_mode    (asc_mode),
        .is_fetch    (req_fetch),
        .is_write    (req_write),
        .prot_enable (lp_enable),
        .dat_on      (xlate_on),
        .elem_pri    (ce_primary),
        .elem_sec    (ce_secondary),
        .elem_home   (ce_home),
        .elem_sel    (dec_elem),
        .perm        (dec_perm),
        .prot_active (dec_prot),
        .unsupported (dec_unsup)
    );

    assign accept  = req_start && (st_q == ST_IDLE);
    assign in_walk = (st_q == ST_WALK);

    lap_page_walker #(
        .AW(AW), .LW(LW), .PAGE_BITS(PAGE_BITS), .LOW_WIN(LOW_WIN)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (in_walk),
        .load_addr (req_addr),
        .load_len  (req_len),
        .load_prot (dec_prot),
        .cur_addr  (page_addr),
        .hit       (hit),
        .last      (last)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (dec_unsup)           st_d = ST_ERR;
                    else if (req_len == '0)  st_d = ST_EMPTY;
                    else                     st_d = ST_WALK;
                end
            end
            ST_WALK:  if (hit || last) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ce_q   <= '0;
            perm_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                ce_q   <= dec_elem;
                perm_q <= dec_perm;
            end
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign page_valid = in_walk && !hit;
    assign prot_fault = in_walk && hit;
    assign mode_error = (st_q == ST_ERR);
    assign walk_done  = (in_walk && !hit && last) || (st_q == ST_EMPTY);
    assign active_ce  = ce_q;
    assign page_perm  = perm_q;

endmodule

// File: rtl/lap_checker_sva.sv
module lap_checker_sva
    import lap_pkg::*;
#(
    parameter int AW        = 64,
    parameter int EW        = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_WIN   = 512
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          page_valid,
    input logic [AW-1:0] page_addr,
    input logic [EW-1:0] active_ce,
    input logic          prot_fault,
    input logic          mode_error,
    input logic          walk_done
);

    localparam logic [AW-1:0] PG_SIZE = AW'(1) << PAGE_BITS;
    localparam logic [AW-1:0] PG_MASK = PG_SIZE - AW'(1);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !page_valid && !prot_fault && !mode_error && !walk_done)); // R1

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({walk_done, prot_fault, mode_error})); // R8

    AST_FAULT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> in_low_window(64'(page_addr), PAGE_BITS, LOW_WIN)); // R6

    AST_FAULT_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> !page_valid); // R6

    AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (rst)
        prot_fault |=> !busy); // R6

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !busy); // R8

    AST_ERR_NO_PAGE: assert property (@(posedge clk) disable iff (rst)
        mode_error |-> (!page_valid && busy)); // R9

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (page_valid && $past(page_valid)) |->
            (page_addr == (($past(page_addr) & ~PG_MASK) + PG_SIZE))); // R7

    AST_CE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(active_ce)); // R11

endmodule

bind lap_checker lap_checker_sva #(
    .AW(AW), .EW(EW), .PAGE_BITS(PAGE_BITS), .LOW_WIN(LOW_WIN)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .page_valid (page_valid),
    .page_addr  (page_addr),
    .active_ce  (active_ce),
    .prot_fault (prot_fault),
    .mode_error (mode_error),
    .walk_done  (walk_done)
);

// File: tb/sim_lap_checker.sv
`timescale 1ns/1ps
module sim_lap_checker;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_start, req_write, req_fetch, lp_enable, xlate_on;
    logic [63:0] req_addr;
    logic [31:0] req_len;
    logic [1:0]  asc_mode;
    logic [63:0] ce_primary, ce_secondary, ce_home;
    logic        busy, page_valid, prot_fault, mode_error, walk_done;
    logic [63:0] page_addr, active_ce;
    logic [2:0]  page_perm;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          n_pages;
    logic [63:0] pages [16];
    bit          got_done, got_fault, got_err;
    int          out_cycle;
    logic [63:0] fault_addr, ce_seen;
    logic [2:0]  perm_seen;

    always #2.5 clk = ~clk;

    lap_checker u0 (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_fetch(req_fetch),
        .lp_enable(lp_enable), .xlate_on(xlate_on), .asc_mode(asc_mode),
        .ce_primary(ce_primary), .ce_secondary(ce_secondary), .ce_home(ce_home),
        .busy(busy), .page_valid(page_valid), .page_addr(page_addr),
        .active_ce(active_ce), .page_perm(page_perm), .prot_fault(prot_fault),
        .mode_error(mode_error), .walk_done(walk_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // Drive one request and record everything seen until it ends.
    task automatic run_req(input logic [63:0] a, input logic [31:0] len,
                           input bit wr, input bit fe, input bit en,
                           input bit dat, input logic [1:0] mode, input bit inject);
        @(negedge clk);
        req_addr = a; req_len = len; req_write = wr; req_fetch = fe;
        lp_enable = en; xlate_on = dat; asc_mode = mode; req_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_start = 1'b0;
        n_pages = 0; got_done = 0; got_fault = 0; got_err = 0;
        out_cycle = -1; fault_addr = '0;
        for (int i = 0; i < 64; i++) begin
            if (i == 0) begin
                ce_seen   = active_ce;
                perm_seen = page_perm;
            end
            if (page_valid && n_pages < 16) begin
                pages[n_pages] = page_addr;
                n_pages++;
            end
            if (walk_done || prot_fault || mode_error) begin
                got_done  = walk_done;
                got_fault = prot_fault;
                got_err   = mode_error;
                fault_addr = page_addr;
                out_cycle = i;
                break;
            end
            if (inject && i == 1) begin
                req_start = 1'b1; req_addr = 64'h0; req_write = 1'b1;
                lp_enable = 1'b1; xlate_on = 1'b0; asc_mode = 2'b11;
            end else begin
                req_start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        req_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_start = 0; req_addr = '0; req_len = '0; req_write = 0;
        req_fetch = 0; lp_enable = 0; xlate_on = 0; asc_mode = 2'b00;
        ce_primary = 64'h1000_0000; ce_secondary = 64'h2000_0000; ce_home = 64'h3000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !page_valid && !prot_fault && !mode_error && !walk_done,
            "R1", "outputs in reset", {busy, page_valid, prot_fault, mode_error, walk_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !walk_done, "R1", "idle after reset", {busy, walk_done}, 0);
    endtask

    task automatic t_primary_multi();
        run_req(64'h1_0010, 32'h2000, 1, 0, 0, 0, 2'b00, 0);
        chk(n_pages == 3, "R7", "page count", n_pages, 3);
        chk(pages[0] == 64'h1_0010, "R7", "first page", pages[0], 64'h1_0010);
        chk(pages[1] == 64'h1_1000, "R7", "second page", pages[1], 64'h1_1000);
        chk(pages[2] == 64'h1_2000, "R7", "third page", pages[2], 64'h1_2000);
        chk(got_done && out_cycle == 2, "R8", "done on last page", out_cycle, 2);
        chk(ce_seen == ce_primary, "R2", "primary element", ce_seen, ce_primary);
        chk(perm_seen == 3'b111, "R2", "primary perm", perm_seen, 3'b111);
    endtask

    task automatic t_home();
        run_req(64'h5_0000, 32'd1, 0, 0, 1, 1, 2'b11, 0);
        chk(ce_seen == ce_home, "R2", "home element", ce_seen, ce_home);
        chk(perm_seen == 3'b111, "R2", "home perm", perm_seen, 3'b111);
        chk(got_done && n_pages == 1, "R8", "single page done", n_pages, 1);
    endtask

    task automatic t_secondary();
        run_req(64'h8_0000, 32'd16, 0, 0, 0, 1, 2'b10, 0);
        chk(ce_seen == ce_secondary, "R3", "secondary data element", ce_seen, ce_secondary);
        chk(perm_seen == 3'b110, "R3", "secondary data perm", perm_seen, 3'b110);
        run_req(64'h8_0000, 32'd16, 0, 1, 0, 1, 2'b10, 0);
        chk(ce_seen == ce_primary, "R3", "secondary fetch element", ce_seen, ce_primary);
        chk(perm_seen == 3'b001, "R3", "secondary fetch perm", perm_seen, 3'b001);
    endtask

    task automatic t_low_first();
        run_req(64'd100, 32'd10, 1, 0, 1, 0, 2'b00, 0);
        chk(got_fault && out_cycle == 0, "R6", "fault on first page", out_cycle, 0);
        chk(n_pages == 0, "R6", "no valid page", n_pages, 0);
        chk(fault_addr == 64'd100, "R6", "fault address", fault_addr, 100);
        run_req(64'd100, 32'd10, 0, 0, 1, 0, 2'b00, 0);
        chk(!got_fault && got_done, "R5", "read not protected", got_fault, 0);
    endtask

    task automatic t_second_page();
        run_req(64'd4000, 32'd200, 1, 0, 1, 0, 2'b00, 0);
        chk(n_pages == 1 && pages[0] == 64'd4000, "R7", "page before fault", pages[0], 4000);
        chk(got_fault && out_cycle == 1, "R6", "fault on second page", out_cycle, 1);
        chk(fault_addr == 64'd4096, "R6", "fault at aligned page", fault_addr, 4096);
        chk(!got_done, "R6", "no done after fault", got_done, 0);
    endtask

    task automatic t_boundaries();
        run_req(64'd511, 32'd1, 1, 0, 1, 0, 2'b00, 0);
        chk(got_fault, "R6", "511 protected", got_fault, 1);
        run_req(64'd512, 32'd1, 1, 0, 1, 0, 2'b00, 0);
        chk(got_done && !got_fault, "R6", "512 unprotected", got_fault, 0);
        run_req(64'd4607, 32'd1, 1, 0, 1, 0, 2'b00, 0);
        chk(got_fault, "R6", "4607 protected", got_fault, 1);
        run_req(64'd4608, 32'd1, 1, 0, 1, 0, 2'b00, 0);
        chk(got_done && !got_fault, "R6", "4608 unprotected", got_fault, 0);
    endtask

    task automatic t_private();
        ce_primary = 64'h1000_0100;
        run_req(64'd0, 32'd8, 1, 0, 1, 1, 2'b00, 0);
        chk(got_done && !got_fault, "R4", "private set, xlate on", got_fault, 0);
        run_req(64'd0, 32'd8, 1, 0, 1, 0, 2'b00, 0);
        chk(got_fault, "R4", "private set, xlate off", got_fault, 1);
        ce_primary = 64'h1000_0000;
        run_req(64'd0, 32'd8, 1, 0, 1, 1, 2'b00, 0);
        chk(got_fault, "R4", "private clear, xlate on", got_fault, 1);
        run_req(64'd0, 32'd8, 1, 0, 0, 0, 2'b00, 0);
        chk(got_done && !got_fault, "R4", "enable off", got_fault, 0);
        ce_secondary = 64'h2000_0100;
        run_req(64'd0, 32'd8, 1, 0, 1, 1, 2'b10, 0);
        chk(got_done && !got_fault, "R4", "secondary private set", got_fault, 0);
        ce_secondary = 64'h2000_0000;
    endtask

    task automatic t_accreg();
        run_req(64'h4_0000, 32'h3000, 1, 0, 1, 1, 2'b01, 0);
        chk(got_err && out_cycle == 0, "R9", "mode error timing", out_cycle, 0);
        chk(n_pages == 0, "R9", "no pages on error", n_pages, 0);
        run_req(64'h4_0000, 32'h10, 1, 0, 0, 0, 2'b01, 0);
        chk(got_done && !got_err, "R9", "xlate off skips mode check", got_err, 0);
    endtask

    task automatic t_zero();
        run_req(64'h9_0000, 32'd0, 1, 0, 1, 0, 2'b00, 0);
        chk(got_done && out_cycle == 0, "R10", "zero length done", out_cycle, 0);
        chk(n_pages == 0, "R10", "zero length pages", n_pages, 0);
    endtask

    task automatic t_busy();
        run_req(64'h2_0000, 32'h3000, 1, 0, 1, 0, 2'b00, 1);
        chk(n_pages == 3, "R11", "page count kept", n_pages, 3);
        chk(pages[1] == 64'h2_1000 && pages[2] == 64'h2_2000, "R11", "sequence kept",
            pages[2], 64'h2_2000);
        chk(got_done && !got_fault, "R11", "no fault from ignored start", got_fault, 0);
        chk(!busy, "R11", "idle after walk", busy, 0);
    endtask

    initial begin
        t_reset();
        t_primary_multi();
        t_home();
        t_secondary();
        t_low_first();
        t_second_page();
        t_boundaries();
        t_private();
        t_accreg();
        t_zero();
        t_busy();
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        finish_run();
    end

endmodule